// File: doc/BRIEF.md
# Indexed Palette Access Port

This block holds a set of colour palettes, each with 256 entries of 9-bit colour, and gives software access to them through four byte-wide registers. An index register picks the entry. A short data register moves the top eight colour bits, and a long data register moves the full nine bits as two bytes in a row. A control register picks which palette the data registers reach. Writes move the shared index forward. Reads leave all state unchanged.

A separate display port reads any palette entry with a fixed latency of one cycle. It runs at the same time as the register port and does not use any of the register state. Register reads are combinational from the current state. Register writes take effect at the clock edge that samples them.

Top module: `pal_access_port`

## Requirements
- R1: After reset the index reads 0, the palette select reads 0, and the long data register expects its first byte.
- R2: A write to the index register (regSel 0) sets the index to wrData. A read with regSel 0 returns the index.
- R3: A read of the short data register (regSel 1) returns colour bits [8:1] of the entry selected by the palette select and the index. A cycle with regWr low changes neither the index nor the palette select.
- R4: A write to the short data register stores colour {wrData, wrData[1] | wrData[0]} at the current entry and then adds one to the index.
- R5: Writes to the long data register (regSel 2) come in pairs. The first byte is held and nothing is stored and the index does not move. The second write stores {first byte, wrData[0]} and adds one to the index. Bits [7:1] of the second byte are ignored.
- R6: A read of the long data register returns {7'b0, colour bit 0} of the current entry.
- R7: A write to the index register discards a pending first byte, so the next long write is taken as a first byte again.
- R8: A write to the control register (regSel 3) sets the palette select from wrData[PAL_W-1:0]. A read returns the select in the same bits, with zeros above. Data reads and writes reach only the selected palette.
- R9: When the index is incremented from 255 it becomes 0.
- R10: dispColor shows the entry at (dispPal, dispIdx) one clock after those inputs are sampled, whatever the register port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Write strobe for the selected register |
| regSel | input | 2 | Register select: 0 index, 1 short data, 2 long data, 3 control |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Combinational read data of the selected register |
| dispPal | input | PAL_W | Display read palette |
| dispIdx | input | 8 | Display read entry |
| dispColor | output | 9 | Display read colour, one cycle latency |

## Verification
A register write is sampled on a rising edge, and its effect can be read on rdData as soon as that edge has passed. The bench drives a write for one cycle from a falling edge and reads at the next falling edge. Register reads need no clock edge, so the bench sets regSel and samples a moment later. A display lookup driven on a falling edge is checked at the following falling edge, after the one rising edge that registers it.

// File: rtl/pal_access_pkg.sv
package pal_access_pkg;
  localparam int IDX_W   = 8;
  localparam int COLOR_W = 9;

  typedef enum logic [1:0] {
    SEL_INDEX = 2'd0,
    SEL_DATA8 = 2'd1,
    SEL_DATA9 = 2'd2,
    SEL_CTRL  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                wrEn;
    logic [COLOR_W-1:0]  color;
  } storeStrobe_t;
endpackage

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_access_pkg::*;
#(
  parameter int PAL_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [1:0]         regSel,
  input  logic [7:0]         wrData,
  input  logic [COLOR_W-1:0] curColor,
  output logic [IDX_W-1:0]   curIdx,
  output logic [PAL_W-1:0]   palSel,
  output storeStrobe_t       strobe,
  output logic [7:0]         rdData
);
  logic       secondHalf;
  logic [7:0] hiByte;
  logic       wrIdx, wrD8, wrD9, wrCtl;

  assign wrIdx = regWr && (regSel == SEL_INDEX);
  assign wrD8  = regWr && (regSel == SEL_DATA8);
  assign wrD9  = regWr && (regSel == SEL_DATA9);
  assign wrCtl = regWr && (regSel == SEL_CTRL);

  always_comb begin
    strobe = '0;
    if (wrD8) begin
      strobe.wrEn  = 1'b1;
      strobe.color = {wrData, wrData[1] | wrData[0]};
    end else if (wrD9 && secondHalf) begin
      strobe.wrEn  = 1'b1;
      strobe.color = {hiByte, wrData[0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx     <= '0;
      palSel     <= '0;
      secondHalf <= 1'b0;
      hiByte     <= '0;
    end else begin
      if (wrIdx) begin
        curIdx     <= wrData;
        secondHalf <= 1'b0;
      end else if (strobe.wrEn) begin
        curIdx <= curIdx + 1'b1;
      end
      if (wrD9) begin
        secondHalf <= !secondHalf;
        if (!secondHalf) hiByte <= wrData;
      end
      if (wrCtl) palSel <= wrData[PAL_W-1:0];
    end
  end

  always_comb begin
    unique case (regSel)
      SEL_INDEX: rdData = curIdx;
      SEL_DATA8: rdData = curColor[COLOR_W-1:1];
      SEL_DATA9: rdData = {7'b0, curColor[0]};
      default:   rdData = {{(8-PAL_W){1'b0}}, palSel};
    endcase
  end

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx |=> curIdx == $past(wrData)); // R2
  AST_DATA8_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wrD8 |=> curIdx == IDX_W'($past(curIdx) + 1)); // R4
  AST_FIRST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (wrD9 && !secondHalf) |=> $stable(curIdx)); // R5
  AST_HALF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    wrIdx |=> !secondHalf); // R7
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> ($stable(curIdx) && $stable(palSel))); // R3
endmodule

// File: rtl/pal_store.sv
module pal_store
  import pal_access_pkg::*;
#(
  parameter int NUM_PAL = 4,
  parameter int PAL_W   = 2
) (
  input  logic               clk,
  input  storeStrobe_t       strobe,
  input  logic [PAL_W-1:0]   palSel,
  input  logic [IDX_W-1:0]   curIdx,
  output logic [COLOR_W-1:0] curColor,
  input  logic [PAL_W-1:0]   dispPal,
  input  logic [IDX_W-1:0]   dispIdx,
  output logic [COLOR_W-1:0] dispColor
);
  localparam int DEPTH  = NUM_PAL << IDX_W;
  localparam int ADDR_W = PAL_W + IDX_W;

  logic [COLOR_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0]  accAddr, dispAddr;

  assign accAddr  = {palSel, curIdx};
  assign dispAddr = {dispPal, dispIdx};
  assign curColor = mem[accAddr];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) mem[accAddr] <= strobe.color;
    dispColor <= mem[dispAddr];
  end
endmodule

// File: rtl/pal_access_port.sv
module pal_access_port
  import pal_access_pkg::*;
#(
  parameter int NUM_PAL = 4,
  localparam int PAL_W  = (NUM_PAL > 1) ? $clog2(NUM_PAL) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic [1:0]       regSel,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [PAL_W-1:0] dispPal,
  input  logic [7:0]       dispIdx,
  output logic [8:0]       dispColor
);
  storeStrobe_t       strobe;
  logic [IDX_W-1:0]   curIdx;
  logic [PAL_W-1:0]   palSel;
  logic [COLOR_W-1:0] curColor;

  pal_ctrl #(.PAL_W(PAL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrData(wrData),
    .curColor(curColor), .curIdx(curIdx), .palSel(palSel), .strobe(strobe),
    .rdData(rdData)
  );

  pal_store #(.NUM_PAL(NUM_PAL), .PAL_W(PAL_W)) store_i (
    .clk(clk), .strobe(strobe), .palSel(palSel), .curIdx(curIdx),
    .curColor(curColor), .dispPal(dispPal), .dispIdx(dispIdx),
    .dispColor(dispColor)
  );
endmodule

// File: tb/pal_access_port_tb_top.sv
module pal_access_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic [1:0] dispPal = 2'd0;
  logic [7:0] dispIdx = 8'd0;
  logic [8:0] dispColor;

  int checks = 0;
  int errors = 0;
  int model [4][256];
  int cur;

  always #2.5 clk = ~clk;

  pal_access_port #(.NUM_PAL(4)) dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regSel(regSel), .wrData(wrData),
    .rdData(rdData), .dispPal(dispPal), .dispIdx(dispIdx), .dispColor(dispColor)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output int v);
    regSel = sel;
    #0.5;
    v = int'(rdData);
  endtask

  function automatic int pat(input int p, input int i);
    return (i * 7 + p * 53 + 3) & 255;
  endfunction

  function automatic int c8(input int d);
    return (d << 1) | (((d >> 1) | d) & 1);
  endfunction

  initial begin
    int v;
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R1 index after reset", v, 0);
    rd(3, v); chk("R1 select after reset", v, 0);
    wr(2, 8'h80); wr(2, 8'h01);
    rd(0, v); chk("R1 long pair from reset", v, 1);
    wr(0, 8'h00);
    rd(1, v); chk("R1 stored high", v, 8'h80);
    rd(2, v); chk("R6 stored low", v, 1);

    // R4 R9: fill every palette through the short register
    for (int p = 0; p < 4; p++) begin
      wr(3, 8'(p));
      rd(3, v); chk("R8 select readback", v, p);
      wr(0, 8'h00);
      for (int i = 0; i < 256; i++) begin
        wr(1, 8'(pat(p, i)));
        model[p][i] = c8(pat(p, i));
      end
      rd(0, v); chk("R9 wrap after 256 writes", v, 0);
    end

    // R3 R6 R2 R8: read back every entry
    for (int p = 0; p < 4; p++) begin
      wr(3, 8'(p));
      for (int i = 0; i < 256; i++) begin
        wr(0, 8'(i));
        rd(1, v); chk("R3 short read", v, model[p][i] >> 1);
        rd(2, v); chk("R6 long read", v, model[p][i] & 1);
        rd(0, v); chk("R2 R3 index unchanged by read", v, i);
      end
    end

    // R10: display sweep while the access port points elsewhere
    wr(3, 8'd1);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        @(negedge clk);
        dispPal = 2'(p); dispIdx = 8'(i);
        @(negedge clk);
        chk("R10 display read", int'(dispColor), model[p][i]);
      end
    end

    // R5 R9: long pairs across the wrap on palette 2
    wr(3, 8'd2);
    wr(0, 8'd250);
    cur = 250;
    for (int k = 0; k < 10; k++) begin
      wr(2, 8'(k * 17 + 1));
      rd(0, v); chk("R5 first byte holds index", v, cur);
      wr(2, 8'(8'hFE | (k & 1)));
      model[2][cur] = (((k * 17 + 1) & 255) << 1) | (k & 1);
      cur = (cur + 1) & 255;
      rd(0, v); chk("R5 R9 index after pair", v, cur);
    end
    for (int i = 250; i < 260; i++) begin
      wr(0, 8'(i & 255));
      rd(1, v); chk("R5 pair high", v, model[2][i & 255] >> 1);
      rd(2, v); chk("R5 pair low", v, model[2][i & 255] & 1);
    end

    // R7: index write discards a pending first byte
    wr(0, 8'd10);
    wr(2, 8'hAA);
    wr(0, 8'd20);
    wr(2, 8'h55);
    wr(2, 8'h01);
    model[2][20] = (8'h55 << 1) | 1;
    rd(0, v); chk("R7 index after restarted pair", v, 21);
    wr(0, 8'd20);
    rd(1, v); chk("R7 new pair high", v, 8'h55);
    rd(2, v); chk("R7 new pair low", v, 1);
    wr(0, 8'd10);
    rd(1, v); chk("R7 abandoned entry intact", v, model[2][10] >> 1);

    // R8: other palettes untouched by palette 2 writes
    wr(3, 8'd1);
    wr(0, 8'd20);
    rd(1, v); chk("R8 palette 1 untouched", v, model[1][20] >> 1);
    rd(2, v); chk("R8 palette 1 low untouched", v, model[1][20] & 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule